// File: doc/BRIEF.md
# TDM Audio Transmit Serializer

This block sends audio samples one bit at a time over a time-division frame of up to eight slots, using I2S/TDM style framing. A one-cycle frame-sync pulse, sampled on a rising serial-clock edge, starts a frame. The block then walks through the configured slots. For each enabled slot it takes a sample from a valid/ready stream, or signals an underrun when none is offered. It formats the sample into a slot image and shifts that image out on the falling edges.

Formatting covers several settings. The sample width is taken from a size code. The sample is picked from the upper or lower end of the input word. Spare slot bit times are filled according to an extension mode. The sample is placed at the start or the end of the slot, and its bit order can be reversed. Two compact-stereo modes unpack two samples from one input word, and a mono mode repeats one sample into a pair of slots. Disabled slots and the time between frames drive a configurable idle level, which can be high impedance through the output-enable.

All configuration inputs are static while a frame is running. The slot width must be at least the sample width.

Top module: `tdm_tx_serializer`

## Requirements
- R1: While reset is asserted, tx_sd is 0, tx_oe is 1, and s_ready and s_underrun are 0. When fsync is high at a rising edge, bit 0 of slot 0 appears on the following falling edge and one bit follows per clock. The frame holds cfg_last_slot+1 slots. After the last slot the line is idle until the next fsync.
- R2: cfg_slot_w sets the slot length: 0 gives 8, 1 gives 16, 2 gives 24 and 3 gives 32 bit times.
- R3: When bit k of cfg_slot_off is 1, slot k takes no sample. During that slot, and outside any frame, the line follows cfg_idle: 0 drives low, 1 drives high, 2 (reserved) drives low, and 3 drives tx_oe to 0.
- R4: cfg_size selects the sample width: 0 gives 32, 1 gives 24, 2 gives 20, 3 gives 18, 4 gives 16, 5 gives 16 compact stereo, 6 gives 8 and 7 gives 8 compact stereo.
- R5: Outside the compact modes, cfg_word_left=0 takes the sample from the low W bits of s_data, and cfg_word_left=1 takes it from the top W bits.
- R6: cfg_slot_left=1 places the sample in the first W bit times of the slot. cfg_slot_left=0 places it in the last W bit times.
- R7: The remaining slot bit times carry a fill value set by cfg_ext: 0 gives zeros, 1 gives ones, 2 gives the sample MSB and 3 gives the sample LSB.
- R8: With cfg_lsb_first=0 the sample is sent MSB first. With cfg_lsb_first=1 its bits are reversed in place and the fill bits are unchanged.
- R9: In compact modes, one input word is fetched at the start of an even slot when that slot or the next slot is enabled. The even slot sends the lower half (bits 15:0 for size 5, bits 7:0 for size 7). The odd slot sends the upper half (bits 31:16 or 15:8).
- R10: With cfg_mono=1, the sample fetched for an even slot is sent again in the following odd slot, and the odd slot takes no sample of its own.
- R11: s_ready is high during the clock cycle whose rising edge starts a slot (or pair) that needs a sample. A sample is taken when s_valid and s_ready are both high. The number of samples consumed per frame equals the number of such slots.
- R12: If s_ready is high while s_valid is low, s_underrun is high in that cycle. The block then sends zero data when cfg_repeat=0, or resends the previously used word when cfg_repeat=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-start pulse, sampled on the rising edge |
| s_data | input | 32 | Sample word |
| s_valid | input | 1 | Sample word offered |
| s_ready | output | 1 | Block takes a sample at this rising edge |
| s_underrun | output | 1 | Sample requested but none offered |
| cfg_slot_off | input | NSLOT | Per-slot disable mask |
| cfg_last_slot | input | log2(NSLOT) | Index of the final slot in a frame |
| cfg_slot_w | input | 2 | Slot length code |
| cfg_size | input | 3 | Sample size code |
| cfg_lsb_first | input | 1 | Reverse the sample bit order |
| cfg_ext | input | 2 | Fill mode for spare bit times |
| cfg_word_left | input | 1 | Take the sample from the top of the input word |
| cfg_slot_left | input | 1 | Place the sample at the start of the slot |
| cfg_mono | input | 1 | Repeat each even-slot sample in the odd slot |
| cfg_idle | input | 2 | Idle line code |
| cfg_repeat | input | 1 | Underrun policy: resend the previous word |
| tx_sd | output | 1 | Serial data, updated on falling edges |
| tx_oe | output | 1 | Output enable for the serial data driver |

## Verification
The embedded properties check, on every cycle, a fixed set of invariants. A frame only starts after a sampled fsync. The slot and bit counters stay inside their configured bounds. The driver is enabled through every enabled slot, and the output floats only under the high-impedance idle code. Bit-exact slot content depends on the combined format settings and the sample order, so only the scoreboard scenarios can show it. That content covers extension fill, justification, reversal, compact unpacking, mono repetition and underrun substitution. Those scenarios also confirm that disabled slots consume no samples.

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer #(
  parameter int NSLOT = 8
) (
  input  logic                     sclk,
  input  logic                     rst_n,
  input  logic                     fsync,
  input  logic [31:0]              s_data,
  input  logic                     s_valid,
  output logic                     s_ready,
  output logic                     s_underrun,
  input  logic [NSLOT-1:0]         cfg_slot_off,
  input  logic [$clog2(NSLOT)-1:0] cfg_last_slot,
  input  logic [1:0]               cfg_slot_w,
  input  logic [2:0]               cfg_size,
  input  logic                     cfg_lsb_first,
  input  logic [1:0]               cfg_ext,
  input  logic                     cfg_word_left,
  input  logic                     cfg_slot_left,
  input  logic                     cfg_mono,
  input  logic [1:0]               cfg_idle,
  input  logic                     cfg_repeat,
  output logic                     tx_sd,
  output logic                     tx_oe
);
  localparam int SIW = $clog2(NSLOT);

  logic            run, cur_en;
  logic [SIW-1:0]  slot, nslot, partner;
  logic [4:0]      bitc;
  logic [5:0]      slot_bits, wbits;
  logic [31:0]     sh, hold, src, samp, word, pad, img, wmask;
  logic            compact, pair, last_bit, load, nen, partner_en, fetch, hi;

  function automatic logic [31:0] rev32(input logic [31:0] v);
    for (int i = 0; i < 32; i++) rev32[i] = v[31-i];
  endfunction

  assign compact    = (cfg_size == 3'd5) || (cfg_size == 3'd7);
  assign pair       = compact || cfg_mono;
  assign slot_bits  = {1'b0, cfg_slot_w, 3'b000} + 6'd8;
  assign last_bit   = bitc == 5'(slot_bits - 6'd1);
  assign load       = fsync || (run && last_bit && slot != cfg_last_slot);
  assign nslot      = fsync ? '0 : slot + 1'b1;
  assign partner    = {nslot[SIW-1:1], 1'b1};
  assign nen        = !cfg_slot_off[nslot];
  assign partner_en = (partner <= cfg_last_slot) && !cfg_slot_off[partner];
  assign fetch      = load && (pair ? (!nslot[0] && (nen || partner_en)) : nen);
  assign s_ready    = fetch;
  assign s_underrun = fetch && !s_valid;
  assign src        = !fetch ? hold : s_valid ? s_data : cfg_repeat ? hold : 32'd0;
  assign hi         = compact && !cfg_mono && nslot[0];

  always_comb begin
    case (cfg_size)
      3'd0:       wbits = 6'd32;
      3'd1:       wbits = 6'd24;
      3'd2:       wbits = 6'd20;
      3'd3:       wbits = 6'd18;
      3'd4, 3'd5: wbits = 6'd16;
      default:    wbits = 6'd8;
    endcase
  end

  assign wmask = (32'd1 << wbits) - 32'd1;

  always_comb begin
    if (cfg_size == 3'd5)      samp = hi ? {16'd0, src[31:16]} : {16'd0, src[15:0]};
    else if (cfg_size == 3'd7) samp = hi ? {24'd0, src[15:8]} : {24'd0, src[7:0]};
    else if (cfg_word_left)    samp = src >> (6'd32 - wbits);
    else                       samp = src & wmask;
  end

  always_comb begin
    case (cfg_ext)
      2'd0:    pad = '0;
      2'd1:    pad = '1;
      2'd2:    pad = {32{samp[5'(wbits - 6'd1)]}};
      default: pad = {32{samp[0]}};
    endcase
  end

  assign word = cfg_lsb_first ? (rev32(samp) >> (6'd32 - wbits)) : samp;
  assign img  = cfg_slot_left
              ? (word << (6'd32 - wbits)) | (pad & ~(wmask << (6'd32 - wbits)))
              : (word << (6'd32 - slot_bits)) | (pad & ~(wmask << (6'd32 - slot_bits)));

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      cur_en <= 1'b0;
      slot   <= '0;
      bitc   <= '0;
      sh     <= '0;
      hold   <= '0;
    end else if (load) begin
      run    <= 1'b1;
      cur_en <= nen;
      slot   <= nslot;
      bitc   <= '0;
      sh     <= img;
      if (fetch) hold <= src;
    end else if (run) begin
      sh   <= sh << 1;
      bitc <= bitc + 5'd1;
      if (last_bit) run <= 1'b0;
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sd <= 1'b0;
      tx_oe <= 1'b1;
    end else if (run && cur_en) begin
      tx_sd <= sh[31];
      tx_oe <= 1'b1;
    end else begin
      tx_sd <= cfg_idle == 2'd1;
      tx_oe <= cfg_idle != 2'd3;
    end
  end

  p_start_on_sync_r1: assert property (@(posedge sclk) disable iff (!rst_n)
    $rose(run) |-> $past(fsync));
  p_slot_bound_r1: assert property (@(posedge sclk) disable iff (!rst_n)
    run |-> slot <= cfg_last_slot);
  p_bit_bound_r2: assert property (@(posedge sclk) disable iff (!rst_n)
    run |-> {1'b0, bitc} < slot_bits);
  p_float_only_idle3_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    !tx_oe |-> cfg_idle == 2'd3);
  p_drive_in_slot_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    (run && cur_en) |-> tx_oe);
endmodule

// File: tb/tdm_tx_serializer_test.sv
module tdm_tx_serializer_test;
  localparam int T = 8;
  localparam int Q = T / 4;

  logic sclk = 0, rst_n = 0, fsync = 0;
  logic [31:0] s_data = 0;
  logic s_valid = 0;
  logic s_ready, s_underrun, tx_sd, tx_oe;
  logic [7:0] cfg_slot_off = 0;
  logic [2:0] cfg_last_slot = 0, cfg_size = 0;
  logic [1:0] cfg_slot_w = 0, cfg_ext = 0, cfg_idle = 0;
  logic cfg_lsb_first = 0, cfg_word_left = 0, cfg_slot_left = 0, cfg_mono = 0, cfg_repeat = 0;

  always #(T/2) sclk = ~sclk;

  tdm_tx_serializer #(.NSLOT(8)) uut (
    .sclk(sclk), .rst_n(rst_n), .fsync(fsync), .s_data(s_data), .s_valid(s_valid),
    .s_ready(s_ready), .s_underrun(s_underrun), .cfg_slot_off(cfg_slot_off),
    .cfg_last_slot(cfg_last_slot), .cfg_slot_w(cfg_slot_w), .cfg_size(cfg_size),
    .cfg_lsb_first(cfg_lsb_first), .cfg_ext(cfg_ext), .cfg_word_left(cfg_word_left),
    .cfg_slot_left(cfg_slot_left), .cfg_mono(cfg_mono), .cfg_idle(cfg_idle),
    .cfg_repeat(cfg_repeat), .tx_sd(tx_sd), .tx_oe(tx_oe));

  int total = 0, bad = 0, und_seen = 0;
  bit exp_sd[$], exp_oe[$];
  logic [31:0] dq[$], words[$];
  logic [31:0] mcur = 0;
  string tag = "";
  bit take = 0;

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge sclk); #Q;
      if (take) begin void'(dq.pop_front()); take = 0; end
      s_valid = dq.size() > 0;
      s_data  = s_valid ? dq[0] : 32'hDEAD_BEEF;
      #(2*Q);
      if (exp_oe.size() > 0) begin
        bit es, eo;
        es = exp_sd.pop_front();
        eo = exp_oe.pop_front();
        check({tag, " oe"}, 32'(tx_oe), 32'(eo));
        if (eo) check({tag, " sd"}, 32'(tx_sd), 32'(es));
      end
      take = s_ready && s_valid;
      if (s_underrun === 1'b1) und_seen++;
    end
  end

  task automatic setc(input int last, input logic [7:0] off, input int sw, input int size,
                      input bit lsb, input int ext, input bit wl, input bit sl,
                      input bit mono, input int idle, input bit rep);
    cfg_last_slot = 3'(last); cfg_slot_off = off; cfg_slot_w = 2'(sw); cfg_size = 3'(size);
    cfg_lsb_first = lsb; cfg_ext = 2'(ext); cfg_word_left = wl; cfg_slot_left = sl;
    cfg_mono = mono; cfg_idle = 2'(idle); cfg_repeat = rep;
  endtask

  task automatic run_frame(string t);
    int ns, S, W, wi, und_exp;
    bit compact, pair, fetch, hi, b;
    logic [31:0] smp;
    ns = int'(cfg_last_slot) + 1;
    S  = (int'(cfg_slot_w) + 1) * 8;
    case (cfg_size)
      3'd0: W = 32; 3'd1: W = 24; 3'd2: W = 20; 3'd3: W = 18;
      3'd4, 3'd5: W = 16; default: W = 8;
    endcase
    compact = (cfg_size == 3'd5) || (cfg_size == 3'd7);
    pair = compact || cfg_mono;
    wi = 0; und_exp = 0;
    @(negedge sclk);
    foreach (words[i]) dq.push_back(words[i]);
    und_seen = 0;
    @(posedge sclk); #Q fsync = 1;
    @(posedge sclk); #Q fsync = 0;
    tag = t;
    for (int k = 0; k < ns; k++) begin
      if (!pair) fetch = !cfg_slot_off[k];
      else if (k % 2 == 0) fetch = !cfg_slot_off[k] || (k + 1 < ns && !cfg_slot_off[k+1]);
      else fetch = 0;
      if (fetch) begin
        if (wi < words.size()) begin mcur = words[wi]; wi++; end
        else begin und_exp++; if (!cfg_repeat) mcur = 0; end
      end
      if (cfg_slot_off[k]) begin
        for (int x = 0; x < S; x++) begin
          exp_sd.push_back(cfg_idle == 2'd1); exp_oe.push_back(cfg_idle != 2'd3);
        end
      end else begin
        hi = compact && !cfg_mono && (k % 2 == 1);
        if (cfg_size == 3'd5) smp = hi ? {16'd0, mcur[31:16]} : {16'd0, mcur[15:0]};
        else if (cfg_size == 3'd7) smp = hi ? {24'd0, mcur[15:8]} : {24'd0, mcur[7:0]};
        else if (cfg_word_left) smp = mcur >> (32 - W);
        else smp = mcur & 32'((64'd1 << W) - 64'd1);
        for (int x = 0; x < S; x++) begin
          int j;
          j = cfg_slot_left ? x : x - (S - W);
          if (j >= 0 && j < W) b = cfg_lsb_first ? smp[j] : smp[W-1-j];
          else case (cfg_ext)
            2'd0: b = 0; 2'd1: b = 1; 2'd2: b = smp[W-1]; default: b = smp[0];
          endcase
          exp_sd.push_back(b); exp_oe.push_back(1'b1);
        end
      end
    end
    for (int x = 0; x < 3; x++) begin
      exp_sd.push_back(cfg_idle == 2'd1); exp_oe.push_back(cfg_idle != 2'd3);
    end
    while (exp_oe.size() > 0) @(posedge sclk);
    @(negedge sclk);
    check({t, " R11 samples consumed"}, 32'(dq.size()), 32'd0);
    check({t, " R12 underrun count"}, 32'(und_seen), 32'(und_exp));
    dq.delete();
    words.delete();
    @(posedge sclk); #Q;
  endtask

  initial begin
    repeat (3) @(posedge sclk);
    #Q;
    check("R1 reset sd", 32'(tx_sd), 32'd0);
    check("R1 reset oe", 32'(tx_oe), 32'd1);
    check("R1 reset ready", 32'(s_ready), 32'd0);
    check("R1 reset underrun", 32'(s_underrun), 32'd0);
    rst_n = 1;
    @(posedge sclk); #Q;

    setc(1, 8'h00, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    words = '{32'hA5C3_0F81, 32'h1234_5678};
    run_frame("R1 R2 R4 R8 32-bit msb-first");

    setc(3, 8'h02, 2, 4, 1, 1, 0, 0, 0, 1, 0);
    words = '{32'h0000_8001, 32'h0000_1234, 32'hFFFF_00F0};
    run_frame("R3 R6 R7 R8 16-in-24 lsb-first ones fill idle high");

    setc(1, 8'h02, 3, 1, 0, 2, 1, 1, 0, 3, 0);
    words = '{32'h9ABC_DE00};
    run_frame("R3 R5 R6 R7 24-bit top of word, msb fill, hi-z");

    setc(1, 8'h00, 2, 2, 0, 3, 0, 0, 0, 0, 0);
    words = '{32'h000F_FFF1, 32'h0008_0000};
    run_frame("R4 R7 20-bit lsb fill");

    setc(1, 8'h00, 2, 3, 0, 2, 0, 1, 0, 0, 0);
    words = '{32'h0002_0001, 32'h0001_FFFE};
    run_frame("R4 R6 R7 18-bit msb fill left");

    setc(3, 8'h00, 1, 5, 0, 0, 0, 0, 0, 0, 0);
    words = '{32'hBBBB_AAAA, 32'hDDDD_CCCC};
    run_frame("R9 compact 16");

    setc(3, 8'h01, 0, 7, 0, 0, 0, 0, 0, 0, 0);
    words = '{32'h0000_2211, 32'h0000_4433};
    run_frame("R9 R3 compact 8 with even slot off");

    setc(3, 8'h00, 1, 4, 0, 0, 0, 0, 1, 0, 0);
    words = '{32'h0000_1357, 32'h0000_2468};
    run_frame("R10 mono 16");

    setc(3, 8'h00, 0, 6, 0, 0, 0, 0, 0, 0, 0);
    words = '{32'h0000_00A5};
    run_frame("R12 underrun sends zero");

    setc(3, 8'h00, 0, 6, 0, 0, 0, 0, 0, 0, 1);
    words = '{32'h0000_003C, 32'h0000_00C3};
    run_frame("R12 underrun repeats word");

    setc(7, 8'hA6, 0, 6, 1, 0, 0, 0, 0, 2, 0);
    words = '{32'h0000_0081, 32'h0000_0042, 32'h0000_0018, 32'h0000_00E7};
    run_frame("R1 R3 R11 eight slots reserved idle");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(T * 200000);
    total++; bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule